// File: doc/BRIEF.md
# UART DMA Ready Signalling

This block produces the two active-low request lines that a DMA controller uses to move characters in and out of a UART. The UART has a transmit FIFO and a receive FIFO, each 16 entries deep. The block reads three things: the occupancy count of each FIFO, the FIFO enable and DMA mode configuration, and a receive timeout pulse. From these it drives a receive-ready line and a transmit-ready line. Both lines come straight from flip-flops, so each one changes one clock after the inputs that cause the change.

There are two signalling styles.

- **Single-transfer.** The line follows the FIFO occupancy directly. Receive-ready is active whenever any character is waiting. Transmit-ready is active whenever the transmit side is empty.
- **Burst.** Receive-ready becomes active once the chosen trigger level is reached, or when a timeout is reported. It then stays active until the receive FIFO has been drained. Transmit-ready becomes active on an empty transmit FIFO and stays active until every entry has been filled.

Burst signalling is used only when the FIFOs are enabled. With the FIFOs disabled, the same occupancy inputs describe a single holding register, and the block falls back to single-transfer behaviour.

Top module: `uart_dma_ready`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, both `rx_ready_n` and `tx_ready_n` are high.
- R2: Burst signalling applies only when `fifo_en` and `burst_sel` are both 1; every other combination gives single-transfer behaviour.
- R3: In single-transfer mode, `rx_ready_n` is low when `rx_count` is nonzero and high when `rx_count` is zero.
- R4: In burst mode, `rx_ready_n` goes low once `rx_count` reaches the trigger level selected by `rx_trig_sel`, with 2'b00 = 1, 2'b01 = 4, 2'b10 = 8 and 2'b11 = 14 characters.
- R5: In burst mode, a high `rx_timeout` while `rx_count` is nonzero drives `rx_ready_n` low, even below the trigger level.
- R6: In burst mode, once `rx_ready_n` is low it stays low until `rx_count` is zero. While it is high, a nonzero count below the trigger level with no timeout keeps it high.
- R7: In single-transfer mode, `tx_ready_n` is low when `tx_count` is zero and high when `tx_count` is one or more.
- R8: In burst mode, `tx_ready_n` goes low when `tx_count` is zero and stays low until `tx_count` equals 16. It then returns high and stays high until `tx_count` is zero again.
- R9: Both outputs are registered. A change on any input shows on the outputs after the next rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_en | input | 1 | FIFOs enabled |
| burst_sel | input | 1 | Selects burst signalling (effective only with `fifo_en`) |
| rx_trig_sel | input | 2 | Receive trigger level code |
| rx_timeout | input | 1 | Receive timeout indication |
| rx_count | input | 5 | Characters held on the receive side (0 to 16) |
| tx_count | input | 5 | Characters held on the transmit side (0 to 16) |
| rx_ready_n | output | 1 | Receive DMA request, active low |
| tx_ready_n | output | 1 | Transmit DMA request, active low |

## Verification
Each output's only internal state is its own registered value, which acts as the burst-mode hold flag. A corrupted hold flag therefore shows at the port at once. It appears either as a receive request dropping before the FIFO is empty, or as a transmit request releasing before the FIFO is full. It is visible on the very next clock edge after the count changes. A wrong trigger decode shows only at the count where the request should first assert. For that reason, the bench ramps the occupancy one step at a time for every trigger code and every mode combination, and compares each cycle against an expected value.

// File: rtl/uart_dma_ready_pkg.sv
// Package: shared types and helpers for the UART DMA ready logic.
// Assumes FIFO depth is a multiple of 4 and at least 4.
package uart_dma_ready_pkg;

    typedef enum logic [1:0] {
        TRIG_ONE     = 2'b00,
        TRIG_QUARTER = 2'b01,
        TRIG_HALF    = 2'b10,
        TRIG_NEARTOP = 2'b11
    } trig_sel_e;

    // Map a trigger code to a character count for a FIFO of the given depth.
    function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
        case (trig_sel_e'(sel))
            TRIG_ONE:     return 1;
            TRIG_QUARTER: return depth / 4;
            TRIG_HALF:    return depth / 2;
            default:      return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/uart_dma_rx_ready.sv
// Module: receive-side DMA request generator.
// What it does: drives an active-low, registered request line from the
// receive occupancy count. In burst mode the request asserts on the trigger
// level or a timeout, and then holds until the count returns to zero.
// Assumes: count never exceeds DEPTH; timeout is a level or pulse from an
// external timer.
module uart_dma_rx_ready
    import uart_dma_ready_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          burst,
    input  logic [1:0]    trig_sel,
    input  logic          timeout,
    input  logic [CW-1:0] count,
    output logic          rdy_n
);

    logic [CW-1:0] trig_cnt;
    logic          has_data;
    logic          at_trig;
    logic          req_next;

    // Decode the trigger code into a count threshold.
    always_comb begin
        trig_cnt = CW'(trig_level(trig_sel, DEPTH));
    end

    // Next request level; the registered output itself serves as the hold flag.
    always_comb begin
        has_data = (count != '0);
        at_trig  = (count >= trig_cnt);
        if (burst) begin
            req_next = has_data && (!rdy_n || at_trig || timeout);
        end else begin
            req_next = has_data;
        end
    end

    // Register the active-low request; inactive on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_n <= 1'b1;
        end else begin
            rdy_n <= !req_next;
        end
    end

endmodule

// File: rtl/uart_dma_tx_ready.sv
// Module: transmit-side DMA request generator.
// What it does: drives an active-low, registered request line from the
// transmit occupancy count. In burst mode the request asserts on an empty
// FIFO and holds until the FIFO is full.
// Assumes: count never exceeds DEPTH.
module uart_dma_tx_ready #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          burst,
    input  logic [CW-1:0] count,
    output logic          rdy_n
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic is_empty;
    logic is_full;
    logic req_next;

    // Next request level from occupancy and the current request state.
    always_comb begin
        is_empty = (count == '0);
        is_full  = (count == FULL_CNT);
        if (burst) begin
            req_next = is_empty || (!rdy_n && !is_full);
        end else begin
            req_next = is_empty;
        end
    end

    // Register the active-low request; inactive on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_n <= 1'b1;
        end else begin
            rdy_n <= !req_next;
        end
    end

endmodule

// File: rtl/uart_dma_ready.sv
// Module: top of the UART DMA ready signalling logic.
// What it does: decodes the effective signalling mode and feeds the receive
// and transmit request generators.
// Assumes: configuration inputs come from registers in the clk domain.
module uart_dma_ready #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          burst_sel,
    input  logic [1:0]    rx_trig_sel,
    input  logic          rx_timeout,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    output logic          rx_ready_n,
    output logic          tx_ready_n
);

    logic burst_mode;

    // Burst signalling only with FIFOs enabled; otherwise single-transfer.
    always_comb begin
        burst_mode = fifo_en && burst_sel;
    end

    uart_dma_rx_ready #(.DEPTH(DEPTH)) rx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .burst    (burst_mode),
        .trig_sel (rx_trig_sel),
        .timeout  (rx_timeout),
        .count    (rx_count),
        .rdy_n    (rx_ready_n)
    );

    uart_dma_tx_ready #(.DEPTH(DEPTH)) tx_i (
        .clk   (clk),
        .rst_n (rst_n),
        .burst (burst_mode),
        .count (tx_count),
        .rdy_n (tx_ready_n)
    );

endmodule

// File: rtl/uart_dma_ready_chk.sv
// Checker: temporal properties of the DMA ready outputs, bound to the top.
module uart_dma_ready_chk #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          burst_sel,
    input logic [1:0]    rx_trig_sel,
    input logic          rx_timeout,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_count,
    input logic          rx_ready_n,
    input logic          tx_ready_n
);

    logic          bm;
    logic [CW-1:0] thr;

    // Independent mode and threshold decode for the checks.
    always_comb begin
        bm = fifo_en & burst_sel;
        unique case (rx_trig_sel)
            2'd0:    thr = CW'(1);
            2'd1:    thr = CW'(DEPTH / 4);
            2'd2:    thr = CW'(DEPTH / 2);
            default: thr = CW'(DEPTH - 2);
        endcase
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rx_ready_n && tx_ready_n));

    assert_rx_empty_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |=> rx_ready_n);

    assert_single_rx_any_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bm && rx_count != '0) |=> !rx_ready_n);

    assert_burst_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bm && rx_count >= thr) |=> !rx_ready_n);

    assert_burst_timeout_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bm && rx_timeout && rx_count != '0) |=> !rx_ready_n);

    assert_burst_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bm && !rx_ready_n && rx_count != '0) |=> !rx_ready_n);

    assert_burst_rx_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bm && rx_ready_n && rx_count < thr && !rx_timeout) |=> rx_ready_n);

    assert_tx_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0) |=> !tx_ready_n);

    assert_single_tx_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bm && tx_count != '0) |=> tx_ready_n);

    assert_burst_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bm && !tx_ready_n && tx_count != CW'(DEPTH)) |=> !tx_ready_n);

    assert_tx_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == CW'(DEPTH)) |=> tx_ready_n);

    assert_tx_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bm && tx_ready_n && tx_count != '0) |=> tx_ready_n);

endmodule

bind uart_dma_ready uart_dma_ready_chk #(.DEPTH(DEPTH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_en     (fifo_en),
    .burst_sel   (burst_sel),
    .rx_trig_sel (rx_trig_sel),
    .rx_timeout  (rx_timeout),
    .rx_count    (rx_count),
    .tx_count    (tx_count),
    .rx_ready_n  (rx_ready_n),
    .tx_ready_n  (tx_ready_n)
);

// File: tb/uart_dma_ready_tb_top.sv
`timescale 1ns/1ps
module uart_dma_ready_tb_top;

    localparam int DEPTH = 16;
    localparam int CW = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_en = 1'b0;
    logic          burst_sel = 1'b0;
    logic [1:0]    rx_trig_sel = 2'd0;
    logic          rx_timeout = 1'b0;
    logic [CW-1:0] rx_count = '0;
    logic [CW-1:0] tx_count = '0;
    logic          rx_ready_n;
    logic          tx_ready_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Expected request states, active-high.
    bit exp_rx = 1'b0;
    bit exp_tx = 1'b0;

    always #4 clk = ~clk;

    uart_dma_ready #(.DEPTH(DEPTH)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_en     (fifo_en),
        .burst_sel   (burst_sel),
        .rx_trig_sel (rx_trig_sel),
        .rx_timeout  (rx_timeout),
        .rx_count    (rx_count),
        .tx_count    (tx_count),
        .rx_ready_n  (rx_ready_n),
        .tx_ready_n  (tx_ready_n)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int trig_of(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    // One clock: update the expected state from the requirements, then compare at the next negedge.
    task automatic step(input string rx_tag, input string tx_tag);
        bit b;
        @(posedge clk);
        b = fifo_en && burst_sel;
        if (b) begin
            exp_rx = (rx_count != 0) && (exp_rx || rx_count >= trig_of(rx_trig_sel) || rx_timeout);
            exp_tx = (tx_count == 0) || (exp_tx && tx_count != DEPTH);
        end else begin
            exp_rx = (rx_count != 0);
            exp_tx = (tx_count == 0);
        end
        @(negedge clk);
        check(rx_tag, rx_ready_n, !exp_rx);
        check(tx_tag, tx_ready_n, !exp_tx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset rx", rx_ready_n, 1'b1);
        check("R1 reset tx", tx_ready_n, 1'b1);
        rst_n = 1'b1;
        #1;
        check("R1 post-reset rx", rx_ready_n, 1'b1);
        check("R1 post-reset tx", tx_ready_n, 1'b1);
        @(negedge clk);
        exp_rx = 1'b0;
        exp_tx = 1'b1;
        check("R7 first cycle tx", tx_ready_n, 1'b0);

        // R9: an input change does not show before the next edge.
        rx_count = 1;
        #1;
        check("R9 rx before edge", rx_ready_n, 1'b1);
        step("R3", "R7");
        check("R3 single rx one char", rx_ready_n, 1'b0);
        rx_count = 0;
        step("R3", "R7");

        // Sweep every mode combination and trigger code with ramps of occupancy.
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 4; s++) begin
                string rt;
                string tt;
                fifo_en = m[0];
                burst_sel = m[1];
                rx_trig_sel = 2'(s);
                rx_count = 0;
                tx_count = 0;
                rt = (m == 3) ? "R4" : "R2";
                tt = (m == 3) ? "R8" : "R7";
                step(rt, tt);
                for (int c = 1; c <= DEPTH; c++) begin
                    rx_count = CW'(c);
                    tx_count = CW'(c);
                    step(rt, tt);
                end
                for (int c = DEPTH - 1; c >= 0; c--) begin
                    rx_count = CW'(c);
                    tx_count = CW'(c);
                    step((m == 3) ? "R6" : "R3", tt);
                end
                // Timeout with a few characters below the trigger level.
                rx_count = 2;
                step(rt, tt);
                rx_timeout = 1'b1;
                step((m == 3) ? "R5" : "R3", tt);
                rx_timeout = 1'b0;
                rx_count = 1;
                step((m == 3) ? "R6" : "R3", tt);
                rx_count = 0;
                step("R6", tt);
            end
        end

        // Directed burst-mode corner cases: trigger code 2'b11 (14 characters).
        fifo_en = 1'b1;
        burst_sel = 1'b1;
        rx_trig_sel = 2'd3;
        rx_count = 13;
        tx_count = 0;
        step("R6", "R8");
        check("R6 below trigger stays high", rx_ready_n, 1'b1);
        rx_count = 14;
        step("R4", "R8");
        check("R4 at trigger 14", rx_ready_n, 1'b0);
        rx_count = 1;
        tx_count = 15;
        step("R6", "R8");
        check("R6 held while draining", rx_ready_n, 1'b0);
        check("R8 held below full", tx_ready_n, 1'b0);
        rx_count = 0;
        tx_count = 16;
        step("R6", "R8");
        check("R6 released on empty", rx_ready_n, 1'b1);
        check("R8 released at full", tx_ready_n, 1'b1);
        rx_count = 3;
        rx_timeout = 1'b1;
        tx_count = 5;
        step("R5", "R8");
        check("R5 timeout asserts", rx_ready_n, 1'b0);
        check("R8 partial stays high", tx_ready_n, 1'b1);
        rx_timeout = 1'b0;

        // R2: burst select without FIFO enable behaves as single-transfer.
        fifo_en = 1'b0;
        rx_count = 0;
        tx_count = 0;
        step("R2", "R2");
        tx_count = 1;
        step("R2", "R2");
        check("R2 tx single-transfer release", tx_ready_n, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule